// File: doc/BRIEF.md
# Display Controller Command Port Decoder

This block sits behind the 16-bit control port of a display controller and turns a pair of port writes into one memory access command. The command is a 16-bit target address plus a 6-bit access code. The low nibble of the code names the memory (video RAM, colour RAM or vertical-scroll RAM) and the direction. Code bit 5 asks for a DMA transfer. The two halves follow a fixed bit layout, and a flag records that the first half has arrived and the second is still owed.

A first word whose top two bits are `10` is a register write, not a command half. The block pulses a strobe that carries a register index and a data byte. Completing a command, or cancelling a half-written one through a data-port access, pulses a clear to the read-prefetch path. A status read drops any half-written command and returns a word in which bit 9 reports an empty write FIFO.

Top module: `cmd_port_decoder`

## Requirements
- R1: A control write while no command is pending, and whose bits 15:14 are not `10`, does three things. It loads address bits 13:0 from word bits 13:0 and code bits 1:0 from word bits 15:14. It sets `pending`. Address bits 15:14 and code bits 5:2 keep their values.
- R2: A control write while `pending` is set loads address bits 15:14 from word bits 1:0 and code bits 5:2 from word bits 7:4. It clears `pending`. Address bits 13:0 and code bits 1:0 keep their values.
- R3: Completing a second word pulses `prefetch_clear` high for one cycle.
- R4: `dma_start` pulses for one cycle when a second word completes with word bit 7 (code bit 5) set while `dma_enable` is high. It stays low in every other case.
- R5: `mem_target` decodes the low code nibble as follows: 0 or 1 give 0 (video RAM), 3 or 8 give 1 (colour RAM), 4 or 5 give 2 (scroll RAM), and every other value gives 3 (none). `mem_write` equals code bit 0 when the target is not 3, and is 0 otherwise.
- R6: A control write with bits 15:14 = `10` while not pending pulses `reg_wr` for one cycle, with `reg_idx` = word bits 12:8 and `reg_data` = word bits 7:0. The address, the code and `pending` are left unchanged.
- R7: A status read clears `pending` without pulsing `prefetch_clear`. From the next cycle until the next read, `status_word` holds bit 9 = `fifo_empty` and every other bit 0.
- R8: A data-port access while pending clears `pending` and pulses `prefetch_clear`. While not pending it has no effect.
- R9: When several strobes arrive in one cycle, a control write takes precedence over a status read, and a status read takes precedence over a data-port access.
- R10: Synchronous active-high reset clears the address, the code, `pending`, all pulses and `status_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_wr | input | 1 | Control port write strobe |
| ctrl_rd | input | 1 | Status read strobe |
| data_acc | input | 1 | Data port read or write strobe |
| wdata | input | 16 | Control port write word |
| dma_enable | input | 1 | Mode bit that allows DMA |
| fifo_empty | input | 1 | Write FIFO is empty |
| cmd_addr | output | 16 | Assembled target address |
| cmd_code | output | 6 | Assembled access code |
| pending | output | 1 | First command half received |
| mem_target | output | 2 | Decoded memory (0 VRAM, 1 CRAM, 2 VSRAM, 3 none) |
| mem_write | output | 1 | Decoded direction, 1 = write |
| reg_wr | output | 1 | Register write strobe |
| reg_idx | output | 5 | Register index |
| reg_data | output | 8 | Register data |
| dma_start | output | 1 | DMA start request pulse |
| prefetch_clear | output | 1 | Clear pulse for the read prefetch state |
| status_word | output | 16 | Status read value |

## Verification
Every register-based result is due exactly one cycle after the strobe edge: the address, the code, `pending`, `reg_wr`, `dma_start`, `prefetch_clear` and `status_word`. `mem_target` and `mem_write` follow the code in the same cycle. The bench drives each strobe for one cycle from a falling edge and lets one rising edge pass. It samples all outputs at the next falling edge, where the one-cycle pulses are still high, and then removes the strobe. Follow-up idle cycles confirm that the pulses have fallen back.

// File: rtl/cmd_port_pkg.sv
package cmd_port_pkg;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned CODE_W    = 6;
  localparam int unsigned IDX_W     = 5;
  localparam int unsigned RDATA_W   = 8;
  localparam int unsigned EMPTY_BIT = 9;
  localparam int unsigned LOW_W     = 14;
  localparam int unsigned HIGH_W    = WORD_W - LOW_W;

  typedef enum logic [1:0] {
    TGT_VRAM  = 2'd0,
    TGT_CRAM  = 2'd1,
    TGT_VSRAM = 2'd2,
    TGT_NONE  = 2'd3
  } mem_tgt_e;

  function automatic logic is_regwr_word(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: 2] == 2'b10;
  endfunction

  function automatic logic [WORD_W-1:0] first_addr(input logic [WORD_W-1:0] old_a,
                                                   input logic [WORD_W-1:0] w);
    return {old_a[WORD_W-1:LOW_W], w[LOW_W-1:0]};
  endfunction

  function automatic logic [WORD_W-1:0] second_addr(input logic [WORD_W-1:0] old_a,
                                                    input logic [WORD_W-1:0] w);
    return {w[HIGH_W-1:0], old_a[LOW_W-1:0]};
  endfunction

  function automatic logic [CODE_W-1:0] first_code(input logic [CODE_W-1:0] old_c,
                                                   input logic [WORD_W-1:0] w);
    return {old_c[CODE_W-1:2], w[WORD_W-1 -: 2]};
  endfunction

  function automatic logic [CODE_W-1:0] second_code(input logic [CODE_W-1:0] old_c,
                                                    input logic [WORD_W-1:0] w);
    return {w[7:4], old_c[1:0]};
  endfunction

  function automatic mem_tgt_e decode_tgt(input logic [CODE_W-1:0] c);
    case (c[3:0])
      4'h0, 4'h1: return TGT_VRAM;
      4'h3, 4'h8: return TGT_CRAM;
      4'h4, 4'h5: return TGT_VSRAM;
      default:    return TGT_NONE;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] status_value(input logic empty);
    logic [WORD_W-1:0] s;
    s = '0;
    s[EMPTY_BIT] = empty;
    return s;
  endfunction
endpackage

// File: rtl/cmd_word_asm.sv
module cmd_word_asm
  import cmd_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_first,
  input  logic              ev_second,
  input  logic              ev_drop,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] addr_q,
  output logic [CODE_W-1:0] code_q,
  output logic              pend_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      code_q <= '0;
      pend_q <= 1'b0;
    end else if (ev_first) begin
      addr_q <= first_addr(addr_q, wdata);
      code_q <= first_code(code_q, wdata);
      pend_q <= 1'b1;
    end else if (ev_second) begin
      addr_q <= second_addr(addr_q, wdata);
      code_q <= second_code(code_q, wdata);
      pend_q <= 1'b0;
    end else if (ev_drop) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cmd_side_pulses.sv
module cmd_side_pulses
  import cmd_port_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               ev_second,
  input  logic               ev_regwr,
  input  logic               ev_cancel,
  input  logic               dma_enable,
  input  logic [WORD_W-1:0]  wdata,
  output logic               reg_wr_q,
  output logic [IDX_W-1:0]   reg_idx_q,
  output logic [RDATA_W-1:0] reg_data_q,
  output logic               dma_q,
  output logic               pfc_q
);
  logic dma_req;
  assign dma_req = ev_second && dma_enable && second_code('0, wdata)[CODE_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_wr_q   <= 1'b0;
      reg_idx_q  <= '0;
      reg_data_q <= '0;
      dma_q      <= 1'b0;
      pfc_q      <= 1'b0;
    end else begin
      reg_wr_q <= ev_regwr;
      dma_q    <= dma_req;
      pfc_q    <= ev_second || ev_cancel;
      if (ev_regwr) begin
        reg_idx_q  <= wdata[8 +: IDX_W];
        reg_data_q <= wdata[RDATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/cmd_status_reg.sv
module cmd_status_reg
  import cmd_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_status,
  input  logic              fifo_empty,
  output logic [WORD_W-1:0] status_q
);
  always_ff @(posedge clk) begin
    if (rst)            status_q <= '0;
    else if (ev_status) status_q <= status_value(fifo_empty);
  end
endmodule

// File: rtl/cmd_port_decoder.sv
module cmd_port_decoder
  import cmd_port_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         ctrl_wr,
  input  logic         ctrl_rd,
  input  logic         data_acc,
  input  logic [15:0]  wdata,
  input  logic         dma_enable,
  input  logic         fifo_empty,
  output logic [15:0]  cmd_addr,
  output logic [5:0]   cmd_code,
  output logic         pending,
  output logic [1:0]   mem_target,
  output logic         mem_write,
  output logic         reg_wr,
  output logic [4:0]   reg_idx,
  output logic [7:0]   reg_data,
  output logic         dma_start,
  output logic         prefetch_clear,
  output logic [15:0]  status_word
);
  logic ev_regwr, ev_first, ev_second, ev_status, ev_cancel, ev_drop;

  // Strobe priority: control write, then status read, then data access.
  assign ev_regwr  = ctrl_wr && !pending && is_regwr_word(wdata);
  assign ev_first  = ctrl_wr && !pending && !is_regwr_word(wdata);
  assign ev_second = ctrl_wr && pending;
  assign ev_status = !ctrl_wr && ctrl_rd;
  assign ev_cancel = !ctrl_wr && !ctrl_rd && data_acc && pending;
  assign ev_drop   = ev_status || ev_cancel;

  cmd_word_asm u_asm (
    .clk(clk), .rst(rst),
    .ev_first(ev_first), .ev_second(ev_second), .ev_drop(ev_drop),
    .wdata(wdata),
    .addr_q(cmd_addr), .code_q(cmd_code), .pend_q(pending)
  );

  cmd_side_pulses u_pulses (
    .clk(clk), .rst(rst),
    .ev_second(ev_second), .ev_regwr(ev_regwr), .ev_cancel(ev_cancel),
    .dma_enable(dma_enable), .wdata(wdata),
    .reg_wr_q(reg_wr), .reg_idx_q(reg_idx), .reg_data_q(reg_data),
    .dma_q(dma_start), .pfc_q(prefetch_clear)
  );

  cmd_status_reg u_status (
    .clk(clk), .rst(rst),
    .ev_status(ev_status), .fifo_empty(fifo_empty),
    .status_q(status_word)
  );

  mem_tgt_e tgt;
  assign tgt        = decode_tgt(cmd_code);
  assign mem_target = tgt;
  assign mem_write  = (tgt != TGT_NONE) && cmd_code[0];
endmodule

// File: rtl/cmd_port_decoder_chk.sv
module cmd_port_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic        ctrl_wr,
  input logic        ctrl_rd,
  input logic        data_acc,
  input logic [15:0] wdata,
  input logic        dma_enable,
  input logic [15:0] cmd_addr,
  input logic [5:0]  cmd_code,
  input logic        pending,
  input logic [1:0]  mem_target,
  input logic        mem_write,
  input logic        reg_wr,
  input logic        dma_start,
  input logic        prefetch_clear,
  input logic        ev_first,
  input logic        ev_second,
  input logic        ev_regwr,
  input logic        ev_status,
  input logic        ev_cancel
);
  // R1
  first_sets_pending_chk: assert property (@(posedge clk) disable iff (rst)
    ev_first |=> pending && cmd_addr[13:0] == $past(wdata[13:0]));
  // R2
  second_loads_high_chk: assert property (@(posedge clk) disable iff (rst)
    ev_second |=> !pending && cmd_addr[15:14] == $past(wdata[1:0]) && cmd_code[5:2] == $past(wdata[7:4]));
  // R3
  prefetch_after_second_chk: assert property (@(posedge clk) disable iff (rst)
    ev_second |=> prefetch_clear);
  // R4
  dma_cause_chk: assert property (@(posedge clk) disable iff (rst)
    dma_start |-> $past(ctrl_wr && pending && wdata[7] && dma_enable));
  // R5
  write_needs_target_chk: assert property (@(posedge clk) disable iff (rst)
    mem_write |-> mem_target != 2'd3);
  // R6
  regwr_keeps_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    ev_regwr |=> reg_wr && !pending && $stable(cmd_addr) && $stable(cmd_code));
  // R7
  status_drops_pending_chk: assert property (@(posedge clk) disable iff (rst)
    ev_status |=> !pending);
  // R8
  cancel_drops_pending_chk: assert property (@(posedge clk) disable iff (rst)
    ev_cancel |=> !pending && prefetch_clear);
  // R9
  single_event_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_first, ev_second, ev_regwr, ev_status, ev_cancel}));
endmodule

bind cmd_port_decoder cmd_port_decoder_chk u_chk (.*);

// File: tb/cmd_port_decoder_test.sv
`timescale 1ns/1ps
module cmd_port_decoder_test;
  logic clk = 1'b0;
  logic rst;
  logic ctrl_wr, ctrl_rd, data_acc, dma_enable, fifo_empty;
  logic [15:0] wdata;
  logic [15:0] cmd_addr, status_word;
  logic [5:0]  cmd_code;
  logic pending, mem_write, reg_wr, dma_start, prefetch_clear;
  logic [1:0]  mem_target;
  logic [4:0]  reg_idx;
  logic [7:0]  reg_data;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmd_port_decoder uut (.*);

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_DA = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] w;
    logic        dma;
    logic [15:0] ea;
    logic [5:0]  ec;
    logic        ep;
    logic        edma;
    logic        epc;
    logic        ereg;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{OP_WR, 16'h4123, 1'b0, 16'h0123, 6'h01, 1'b1, 1'b0, 1'b0, 1'b0},
    '{OP_WR, 16'h0002, 1'b0, 16'h8123, 6'h01, 1'b0, 1'b0, 1'b1, 1'b0},
    '{OP_WR, 16'h0000, 1'b0, 16'h8000, 6'h00, 1'b1, 1'b0, 1'b0, 1'b0},
    '{OP_WR, 16'h0020, 1'b0, 16'h0000, 6'h08, 1'b0, 1'b0, 1'b1, 1'b0},
    '{OP_WR, 16'h8A55, 1'b0, 16'h0000, 6'h08, 1'b0, 1'b0, 1'b0, 1'b1},
    '{OP_WR, 16'h5FFF, 1'b0, 16'h1FFF, 6'h09, 1'b1, 1'b0, 1'b0, 1'b0},
    '{OP_DA, 16'h0000, 1'b0, 16'h1FFF, 6'h09, 1'b0, 1'b0, 1'b1, 1'b0},
    '{OP_WR, 16'h4004, 1'b0, 16'h0004, 6'h09, 1'b1, 1'b0, 1'b0, 1'b0},
    '{OP_RD, 16'h0000, 1'b0, 16'h0004, 6'h09, 1'b0, 1'b0, 1'b0, 1'b0},
    '{OP_WR, 16'h4000, 1'b0, 16'h0000, 6'h09, 1'b1, 1'b0, 1'b0, 1'b0},
    '{OP_WR, 16'h0083, 1'b1, 16'hC000, 6'h21, 1'b0, 1'b1, 1'b1, 1'b0},
    '{OP_WR, 16'h4000, 1'b0, 16'hC000, 6'h21, 1'b1, 1'b0, 1'b0, 1'b0},
    '{OP_WR, 16'h0080, 1'b0, 16'h0000, 6'h21, 1'b0, 1'b0, 1'b1, 1'b0},
    '{OP_WR, 16'h1234, 1'b0, 16'h1234, 6'h20, 1'b1, 1'b0, 1'b0, 1'b0},
    '{OP_WR, 16'h8155, 1'b1, 16'h5234, 6'h14, 1'b0, 1'b0, 1'b1, 1'b0},
    '{OP_DA, 16'h0000, 1'b0, 16'h5234, 6'h14, 1'b0, 1'b0, 1'b0, 1'b0},
    '{OP_RD, 16'h0000, 1'b0, 16'h5234, 6'h14, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  // Independent restatement of the target map: returns {target, write}.
  function automatic logic [2:0] exp_tgt(input logic [5:0] c);
    logic [3:0] n;
    n = c[3:0];
    if (n <= 4'd1)                 return {2'd0, n[0]};
    else if (n == 4'd3)            return {2'd1, 1'b1};
    else if (n == 4'd8)            return {2'd1, 1'b0};
    else if (n == 4'd4 || n == 4'd5) return {2'd2, n[0]};
    else                           return {2'd3, 1'b0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    ctrl_wr = 0; ctrl_rd = 0; data_acc = 0; wdata = '0; dma_enable = 0;
  endtask

  // Apply strobes for one cycle; return at the falling edge after capture.
  task automatic step(input logic wr, input logic rd, input logic da,
                      input logic [15:0] w, input logic dma);
    @(negedge clk);
    ctrl_wr = wr; ctrl_rd = rd; data_acc = da; wdata = w; dma_enable = dma;
    @(negedge clk);
    idle();
  endtask

  initial begin
    idle();
    fifo_empty = 1'b1;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check("R10 addr", cmd_addr, 16'h0);
    check("R10 code", cmd_code, 6'h0);
    check("R10 pending", pending, 1'b0);
    check("R10 pulses", {reg_wr, dma_start, prefetch_clear}, 3'b000);
    check("R10 status", status_word, 16'h0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].op == OP_WR, VEC[i].op == OP_RD, VEC[i].op == OP_DA, VEC[i].w, VEC[i].dma);
      // R1 R2 R6 R8 address/code/pending after each vector
      check($sformatf("R1/R2 addr v%0d", i), cmd_addr, VEC[i].ea);
      check($sformatf("R1/R2 code v%0d", i), cmd_code, VEC[i].ec);
      check($sformatf("R8 pending v%0d", i), pending, VEC[i].ep);
      check($sformatf("R4 dma_start v%0d", i), dma_start, VEC[i].edma);
      check($sformatf("R3 prefetch_clear v%0d", i), prefetch_clear, VEC[i].epc);
      check($sformatf("R6 reg_wr v%0d", i), reg_wr, VEC[i].ereg);
      check($sformatf("R5 target v%0d", i), {mem_target, mem_write}, exp_tgt(VEC[i].ec));
      if (VEC[i].ereg) begin
        check("R6 reg_idx", reg_idx, 5'h0A);
        check("R6 reg_data", reg_data, 8'h55);
      end
    end

    // R4: pulses fall back after one cycle
    step(1, 0, 0, 16'h4000, 0);
    step(1, 0, 0, 16'h00F0, 1);
    check("R4 dma pulse", dma_start, 1'b1);
    @(negedge clk);
    check("R4 dma single cycle", dma_start, 1'b0);
    check("R3 prefetch single cycle", prefetch_clear, 1'b0);

    // R7: status word value for both FIFO states
    fifo_empty = 1'b0;
    step(0, 1, 0, 16'h0, 0);
    check("R7 status not empty", status_word, 16'h0000);
    fifo_empty = 1'b1;
    step(0, 1, 0, 16'h0, 0);
    check("R7 status empty", status_word, 16'h0200);
    fifo_empty = 1'b0;
    @(negedge clk);
    check("R7 status held", status_word, 16'h0200);

    // R9: control write beats data access while pending
    step(1, 0, 0, 16'h0111, 0);
    check("R9 setup pending", pending, 1'b1);
    step(1, 0, 1, 16'h0002, 0);
    check("R9 write wins addr", cmd_addr, 16'h8111);
    check("R9 write wins pending", pending, 1'b0);
    // R9: status read beats data access (no prefetch pulse)
    step(1, 0, 0, 16'h0222, 0);
    step(0, 1, 1, 16'h0, 0);
    check("R9 read wins pending", pending, 1'b0);
    check("R9 read wins no prefetch", prefetch_clear, 1'b0);

    // R10: reset in mid command
    step(1, 0, 0, 16'h7FFF, 0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 mid reset pending", pending, 1'b0);
    check("R10 mid reset addr", cmd_addr, 16'h0);
    check("R10 mid reset status", status_word, 16'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule